// File: doc/BRIEF.md
# Oscillator Frequency Capture Timer

This block measures a slow, asynchronous external clock against the fast system clock. A free-running counter advances on timer ticks derived from the system clock. The external clock is brought into the system clock domain and divided by eight. Each falling edge of that divided clock copies the running count into a capture register and raises a sticky flag. Software reads two successive captured values, and their difference (modulo 2^16) gives the number of timer ticks in eight external periods. From that the external frequency follows. For example, with 24 MHz ticks a difference of 5984 means about 32.086 kHz.

The capture register also acts as the counter's reload value. When the counter passes its all-ones value, it restarts from the last captured count rather than from zero. A capture never disturbs the counter. The interrupt output follows the flag. A tick-rate select picks between one tick per system clock and one tick per twelve system clocks.

Top module: `osc_capture_timer`

## Requirements
- R1: While reset is asserted and right after it is released, `cap_val_o` is 0 and both `cap_flag_o` and `irq_o` are 0.
- R2: The external clock passes two synchronizer flops and then a divide-by-8 stage. A capture event happens on every 8th rising edge of the synchronized external clock, counting from reset. That is the falling edge of the divided clock. With a steady external period of P system clocks in fast mode, successive captured values differ by 8*P.
- R3: On a capture event, `cap_val_o` takes the counter value held in the cycle of the event. It shows that value after the next clock edge. A sampled rising edge of `ext_clk_i` leads to the event three clock edges after it was sampled.
- R4: A capture event sets `cap_flag_o` to 1. The flag stays 1 until `flag_clr_i` is high in a cycle with no capture event, and then it drops to 0 after that edge.
- R5: If a capture event and `flag_clr_i` happen in the same cycle, the flag is 1 afterwards.
- R6: While `cap_en_i` is 0, capture events change neither `cap_val_o` nor `cap_flag_o`. The divide-by-8 stage keeps counting rising edges.
- R7: With `fast_tick_i` = 1 the counter advances on every clock. With `fast_tick_i` = 0 it advances once every 12 clocks, on a free-running modulo-12 phase that starts at reset.
- R8: A capture event neither resets nor reloads the counter. The counter keeps advancing through it.
- R9: When the counter advances from 0xFFFF, it loads the current captured value instead of 0.
- R10: `irq_o` equals `cap_flag_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External clock to be measured, asynchronous |
| cap_en_i | input | 1 | Capture enable |
| fast_tick_i | input | 1 | 1: tick every clock, 0: tick every 12 clocks |
| flag_clr_i | input | 1 | Clears the capture flag |
| cap_val_o | output | 16 | Last captured count (also the reload value) |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request, follows the flag |

## Verification
The external clock is driven with a steady 40-cycle period in fast mode, so the difference between successive captures must be exactly 320. This separates a correct divide-by-8 from a wrong divide ratio or a capture on the wrong edge. The same waveform in slow mode must give differences of 26 or 27, which shows that the 12-clock tick phase is honoured.

A long stretch with no external edges drives the counter through 0xFFFF. The next capture then shows whether the counter wrapped to zero or reloaded the captured value. Further stretches do three things:
- hold the clear input high across captures, which checks that set wins over clear;
- pulse the clear input alone;
- run edges with capture disabled, which must leave the outputs frozen.

A behavioural model compares all three outputs on every clock through all of these stretches.

// File: rtl/osct_pkg.sv
package osct_pkg;
   // Default geometry of the capture timer
   localparam int unsigned CNT_W_DEF     = 16;
   localparam int unsigned DIV_LOG2_DEF  = 3;
   localparam int unsigned SLOW_DIV_DEF  = 12;
   localparam int unsigned SYNC_DEF      = 2;

   typedef enum logic {
      TICK_SLOW = 1'b0,
      TICK_FAST = 1'b1
   } tick_mode_e;
endpackage

// File: rtl/osct_sync.sv
module osct_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("osct_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/osct_edge_div.sv
module osct_edge_div #(
   parameter int unsigned DIV_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   output logic cap_evt_o
);
   generate
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("osct_edge_div: DIV_LOG2 must be at least 1");
      end
   endgenerate

   localparam logic [DIV_LOG2-1:0] DIV_LAST = '1;

   logic                sync_d_q;
   logic                rise;
   logic [DIV_LOG2-1:0] div_q;

   assign rise      = sync_i & ~sync_d_q;
   // divided clock MSB falls when the counter leaves its last state
   assign cap_evt_o = rise && (div_q == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_d_q <= 1'b0;
         div_q    <= '0;
      end else begin
         sync_d_q <= sync_i;
         if (rise) div_q <= div_q + 1'b1;
      end
   end

   // R2
   evt_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt_o |=> !cap_evt_o);

   // R2
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(div_q));
endmodule

// File: rtl/osct_tick.sv
module osct_tick #(
   parameter int unsigned SLOW_DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_i,
   output logic tick_o
);
   generate
      if (SLOW_DIV < 1) begin : g_bad_slow
         $error("osct_tick: SLOW_DIV must be at least 1");
      end
   endgenerate

   generate
      if (SLOW_DIV == 1) begin : g_no_presc
         assign tick_o = 1'b1;
      end else begin : g_presc
         localparam int unsigned PW = $clog2(SLOW_DIV);
         localparam logic [PW-1:0] PLAST = PW'(SLOW_DIV - 1);
         logic [PW-1:0] presc_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               presc_q <= '0;
            else if (presc_q == PLAST) presc_q <= '0;
            else                       presc_q <= presc_q + 1'b1;
         end

         assign tick_o = fast_i | (presc_q == PLAST);

         // R7
         slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_o && !fast_i) |=> (!tick_o || fast_i));
      end
   endgenerate
endmodule

// File: rtl/osc_capture_timer.sv
module osc_capture_timer
   import osct_pkg::*;
#(
   parameter int unsigned CNT_W    = CNT_W_DEF,
   parameter int unsigned DIV_LOG2 = DIV_LOG2_DEF,
   parameter int unsigned SLOW_DIV = SLOW_DIV_DEF,
   parameter int unsigned SYNC_STG = SYNC_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_i,
   input  logic             cap_en_i,
   input  logic             fast_tick_i,
   input  logic             flag_clr_i,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             cap_flag_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("osc_capture_timer: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             ext_sync;
   logic             cap_evt;
   logic             tick;
   logic             cap_hit;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;
   logic             flag_q;

   osct_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ext_clk_i),
      .sync_o  (ext_sync)
   );

   osct_edge_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (ext_sync),
      .cap_evt_o (cap_evt)
   );

   osct_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .fast_i (fast_tick_i),
      .tick_o (tick)
   );

   assign cap_hit = cap_evt & cap_en_i;

   // free-running counter, reloads from the capture register on wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (tick && cnt_q == CNT_TOP) cnt_q <= cap_q;
      else if (tick)                   cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q <= '0;
      else if (cap_hit) cap_q <= cnt_q;
   end

   // set dominates clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (cap_hit)    flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign cap_val_o  = cap_q;
   assign cap_flag_o = flag_q;
   assign irq_o      = flag_q;

   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> cap_flag_o);

   // R4
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

   // R5
   flag_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && flag_clr_i) |=> cap_flag_o);

   // R3
   cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> (cap_val_o == $past(cnt_q)));

   // R6
   cap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_hit |=> $stable(cap_val_o));

   // R8
   cnt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q != CNT_TOP) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R9
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q == CNT_TOP) |=> (cnt_q == $past(cap_q)));

   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
endmodule

// File: tb/osc_capture_timer_bench.sv
module osc_capture_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk_i = 1'b0;
   logic        cap_en_i = 1'b0;
   logic        fast_tick_i = 1'b1;
   logic        flag_clr_i = 1'b0;
   logic [15:0] cap_val_o;
   logic        cap_flag_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   string phase_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   osc_capture_timer u_osc_capture_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_clk_i   (ext_clk_i),
      .cap_en_i    (cap_en_i),
      .fast_tick_i (fast_tick_i),
      .flag_clr_i  (flag_clr_i),
      .cap_val_o   (cap_val_o),
      .cap_flag_o  (cap_flag_o),
      .irq_o       (irq_o)
   );

   // behavioural reference model
   bit hq[$] = '{0, 0, 0};
   int m_div = 0, m_pre = 0, m_cnt = 0, m_cap = 0;
   bit m_flag = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hq = '{0, 0, 0}; m_div = 0; m_pre = 0; m_cnt = 0; m_cap = 0; m_flag = 0;
      end else begin
         bit rise, evt, tk;
         int old_cnt, old_cap;
         rise = hq[1] && !hq[2];
         evt  = rise && (m_div == 7);
         if (rise) m_div = (m_div + 1) % 8;
         tk = fast_tick_i || (m_pre == 11);
         m_pre = (m_pre + 1) % 12;
         old_cnt = m_cnt; old_cap = m_cap;
         if (cap_en_i && evt) begin m_cap = old_cnt; m_flag = 1; end
         else if (flag_clr_i) m_flag = 0;
         if (tk) m_cnt = (old_cnt == 65535) ? old_cap : old_cnt + 1;
         hq.push_front(ext_clk_i);
         void'(hq.pop_back());
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // record captured values as they appear
   int caps[$];
   int last_cap = 0;
   int flag_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         check(phase_req, "cap_val_o (R3)", cap_val_o, m_cap);
         check(phase_req, "cap_flag_o (R4)", cap_flag_o, m_flag);
         check("R10", "irq_o", irq_o, cap_flag_o);
         if (cap_val_o != last_cap) begin
            caps.push_back(cap_val_o);
            last_cap = cap_val_o;
         end
         if (cap_flag_o) flag_seen++;
      end
   end

   task automatic run_ext(int rises, int half);
      repeat (rises) begin
         ext_clk_i = 1'b1; repeat (half) @(negedge clk);
         ext_clk_i = 1'b0; repeat (half) @(negedge clk);
      end
   endtask

   function automatic int last_diff();
      return (caps[$] - caps[$-1]) & 16'hFFFF;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "cap_val_o in reset", cap_val_o, 0);
      check("R1", "cap_flag_o in reset", cap_flag_o, 0);
      check("R1", "irq_o in reset", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "cap_val_o after reset", cap_val_o, 0);

      // R2 fast mode, 40-cycle period
      phase_req = "R2"; cap_en_i = 1'b1; fast_tick_i = 1'b1;
      run_ext(24, 20);
      repeat (5) @(negedge clk);
      check("R2", "capture count", caps.size() >= 2, 1);
      if (caps.size() >= 2) check("R2", "capture difference", last_diff(), 320);

      // R4 clear alone
      phase_req = "R4";
      flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0; @(negedge clk);
      check("R4", "flag after clear", cap_flag_o, 0);

      // R5 clear held across a capture
      phase_req = "R5"; flag_seen = 0; flag_clr_i = 1'b1;
      run_ext(8, 20);
      repeat (5) @(negedge clk);
      check("R5", "flag set while clear held", flag_seen > 0, 1);
      flag_clr_i = 1'b0;

      // R6 capture disabled
      phase_req = "R6"; cap_en_i = 1'b0;
      begin
         int before_cnt;
         before_cnt = caps.size();
         run_ext(16, 20);
         repeat (5) @(negedge clk);
         check("R6", "no new captures", caps.size(), before_cnt);
         check("R6", "flag stays clear", cap_flag_o, 0);
      end

      // R7 slow ticks
      phase_req = "R7"; cap_en_i = 1'b1; fast_tick_i = 1'b0;
      run_ext(24, 20);
      repeat (5) @(negedge clk);
      begin
         int d;
         d = last_diff();
         check("R7", "slow difference 26 or 27", (d == 26) || (d == 27), 1);
      end

      // R8 / R9 counter runs on and wraps to the captured value
      phase_req = "R9"; fast_tick_i = 1'b1;
      repeat (70000) @(negedge clk);
      phase_req = "R8";
      run_ext(16, 20);
      repeat (5) @(negedge clk);
      check("R8", "differences after wrap", last_diff(), 320);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule